// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a 32-bit load/store pipeline and a byte-addressed data memory whose words are 32 bits wide. On the store side, it turns an access kind, an effective address and a register value into per-byte write enables and a write word. The write word carries the stored value copied into every lane, so the enables alone decide which bytes of memory change. All store-side outputs are combinational.

On the load side, the unit captures the access kind and the low address bits when the request is issued. In the following cycle the memory read word arrives, and the unit picks out the addressed byte, halfword or word. It then zero-extends or sign-extends that field to 32 bits. An upper-immediate request takes the same one-cycle path but ignores memory. It returns the 16-bit immediate in the upper half of the result and zeros in the lower half.

A halfword at an odd address, or a word whose two low address bits are not both zero, raises a misalignment flag in the request cycle. That request writes no byte and produces no load result.

Top module: `lsu_lane_align`

## Requirements
- R1: A valid store of kind word (code 0) at an address with bits 1:0 equal to 00 drives byte enables 1111, and the write word equals the store value.
- R2: A valid store of a halfword kind (code 1 or 2) at an even address enables lanes 1:0 when address bit 1 is 0 (enable 0011) and lanes 3:2 when it is 1 (enable 1100). The write word is the low 16 bits of the store value written twice.
- R3: A valid store of a byte kind (code 3 or 4) enables exactly the lane given by address bits 1:0, where lane 0 is bits 7:0. The write word is the low byte of the store value written four times.
- R4: A halfword access with address bit 0 set, or a word access with address bits 1:0 not 00, drives the misalignment flag high in the same cycle. The same request drives all byte enables low and produces no load result in the next cycle. A byte access is never misaligned.
- R5: A signed halfword load (code 1) or signed byte load (code 3) returns the selected field with its top bit copied into all upper result bits. The field is selected by address bit 1 for a halfword and by address bits 1:0 for a byte.
- R6: An unsigned halfword load (code 2) or unsigned byte load (code 4) returns the selected field with zeros in all upper result bits.
- R7: A word load (code 0) returns the memory read word unchanged.
- R8: An upper-immediate load (code 5) returns the 16-bit immediate in bits 31:16 and zeros in bits 15:0, whatever the memory read word holds.
- R9: For an aligned load request, the load-valid output is high in exactly the next cycle. The result in that cycle is formed from the memory read word presented in that cycle.
- R10: When no request is valid, all byte enables are low, the misalignment flag is low, and load-valid is low in the next cycle.
- R11: During and right after reset, load-valid is low.
- R12: Kind codes 6 and 7 are reserved, and so is code 5 on a store. Such requests enable no byte, raise no misalignment and produce no load result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqIsStore | input | 1 | 1 for a store, 0 for a load or upper-immediate |
| accessKind | input | 3 | 0 word, 1 signed half, 2 unsigned half, 3 signed byte, 4 unsigned byte, 5 upper immediate, 6 and 7 reserved |
| addr | input | 32 | Effective byte address |
| storeData | input | 32 | Register value to store |
| upperImm | input | 16 | Immediate for the upper-immediate operation |
| memRdata | input | 32 | Memory read word, presented one cycle after the load request |
| memByteEn | output | 4 | Per-lane write enables, bit i writes bits 8i+7:8i |
| memWdata | output | 32 | Lane-replicated write word |
| misaligned | output | 1 | Request is misaligned for its size |
| loadValid | output | 1 | Load result valid this cycle |
| loadResult | output | 32 | Extended load result or upper-immediate value |

## Verification
The hardest case to reach is a misaligned load whose memory word still arrives in the next cycle. The unit must stay silent even though plausible data sits on the read port. The stimulus issues misaligned halfword and word loads and drives a distinctive read word in the following cycle. The scoreboard then expects load-valid low in that cycle. Sign extension is driven for every lane with field values whose top bit is set and with values whose top bit is clear, so a wrong lane or a wrong fill value shows up as a mismatch.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANES      = DATA_W / BYTE_W;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);
  localparam int unsigned HALF_W     = 2 * BYTE_W;
  localparam int unsigned IMM_W      = DATA_W / 2;
  localparam int unsigned KIND_W     = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_WORD   = 3'd0,
    KIND_HALF_S = 3'd1,
    KIND_HALF_U = 3'd2,
    KIND_BYTE_S = 3'd3,
    KIND_BYTE_U = 3'd4,
    KIND_UPPER  = 3'd5,
    KIND_RSV6   = 3'd6,
    KIND_RSV7   = 3'd7
  } accessKind_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_UPPER = 2'd3
  } accessSize_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic [LANES-1:0]      laneEn;
    logic                  loadGo;
    logic                  misalign;
    accessSize_e           size;
    logic                  signExt;
    logic [LANE_IDX_W-1:0] lane;
  } alignStrobe_t;

endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic                  reqValid,
  input  logic                  reqIsStore,
  input  logic [KIND_W-1:0]     accessKind,
  input  logic [LANE_IDX_W-1:0] addrLow,
  output alignStrobe_t          strobe
);

  accessSize_e size;
  logic        signExt;
  logic        legalLoad;
  logic        legalStore;
  logic        misalignRaw;
  logic        storeGo;
  logic [LANES-1:0] laneHit;

  // Decode the kind into size, extension and legality
  always_comb begin
    size       = SZ_WORD;
    signExt    = 1'b0;
    legalLoad  = 1'b0;
    legalStore = 1'b0;
    unique case (accessKind_e'(accessKind))
      KIND_WORD: begin
        size = SZ_WORD; legalLoad = 1'b1; legalStore = 1'b1;
      end
      KIND_HALF_S: begin
        size = SZ_HALF; signExt = 1'b1; legalLoad = 1'b1; legalStore = 1'b1;
      end
      KIND_HALF_U: begin
        size = SZ_HALF; legalLoad = 1'b1; legalStore = 1'b1;
      end
      KIND_BYTE_S: begin
        size = SZ_BYTE; signExt = 1'b1; legalLoad = 1'b1; legalStore = 1'b1;
      end
      KIND_BYTE_U: begin
        size = SZ_BYTE; legalLoad = 1'b1; legalStore = 1'b1;
      end
      KIND_UPPER: begin
        size = SZ_UPPER; legalLoad = 1'b1;
      end
      default: begin
        size = SZ_WORD;
      end
    endcase
  end

  // Alignment rule per size
  always_comb begin
    misalignRaw = 1'b0;
    if (size == SZ_HALF) begin
      misalignRaw = addrLow[0];
    end else if (size == SZ_WORD) begin
      misalignRaw = (addrLow != '0);
    end
  end

  logic legalNow;
  assign legalNow = reqIsStore ? legalStore : legalLoad;

  logic misalignOut;
  assign misalignOut = reqValid && legalNow && misalignRaw;
  assign storeGo     = reqValid && reqIsStore && legalStore && !misalignRaw;

  // Lane hit per size, one lane at a time
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANE_IDX_W-1:0] laneId;
    assign laneId = LANE_IDX_W'(gi);
    always_comb begin
      unique case (size)
        SZ_BYTE: laneHit[gi] = (laneId == addrLow);
        SZ_HALF: laneHit[gi] = ((laneId >> 1) == (addrLow >> 1));
        SZ_WORD: laneHit[gi] = 1'b1;
        default: laneHit[gi] = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.laneEn   = storeGo ? laneHit : '0;
    strobe.loadGo   = reqValid && !reqIsStore && legalLoad && !misalignRaw;
    strobe.misalign = misalignOut;
    strobe.size     = size;
    strobe.signExt  = signExt;
    strobe.lane     = addrLow;
  end

endmodule

// File: rtl/lsu_align_dpath.sv
module lsu_align_dpath
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobe_t      strobe,
  input  logic [DATA_W-1:0] storeData,
  input  logic [IMM_W-1:0]  upperImm,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadResult
);

  // Store path: replicate the field into every lane
  for (genvar gi = 0; gi < LANES; gi++) begin : g_wlane
    always_comb begin
      unique case (strobe.size)
        SZ_BYTE: memWdata[gi*BYTE_W +: BYTE_W] = storeData[BYTE_W-1:0];
        SZ_HALF: memWdata[gi*BYTE_W +: BYTE_W] = storeData[(gi%2)*BYTE_W +: BYTE_W];
        default: memWdata[gi*BYTE_W +: BYTE_W] = storeData[gi*BYTE_W +: BYTE_W];
      endcase
    end
  end

  // Load path: capture control at the request, format data one cycle later
  logic                  validQ;
  accessSize_e           sizeQ;
  logic                  signQ;
  logic [LANE_IDX_W-1:0] laneQ;
  logic [IMM_W-1:0]      immQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      sizeQ  <= SZ_WORD;
      signQ  <= 1'b0;
      laneQ  <= '0;
      immQ   <= '0;
    end else begin
      validQ <= strobe.loadGo;
      if (strobe.loadGo) begin
        sizeQ <= strobe.size;
        signQ <= strobe.signExt;
        laneQ <= strobe.lane;
        immQ  <= upperImm;
      end
    end
  end

  logic [BYTE_W-1:0] byteSel;
  logic [HALF_W-1:0] halfSel;

  assign byteSel = memRdata[{laneQ, 3'b000} +: BYTE_W];
  assign halfSel = memRdata[{laneQ[LANE_IDX_W-1:1], 4'b0000} +: HALF_W];

  always_comb begin
    loadResult = '0;
    if (validQ) begin
      unique case (sizeQ)
        SZ_BYTE:  loadResult = {{(DATA_W-BYTE_W){signQ & byteSel[BYTE_W-1]}}, byteSel};
        SZ_HALF:  loadResult = {{(DATA_W-HALF_W){signQ & halfSel[HALF_W-1]}}, halfSel};
        SZ_UPPER: loadResult = {immQ, {(DATA_W-IMM_W){1'b0}}};
        default:  loadResult = memRdata;
      endcase
    end
  end

  assign loadValid = validQ;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsStore,
  input  logic [KIND_W-1:0] accessKind,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [IMM_W-1:0]  upperImm,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic              misaligned,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadResult
);

  alignStrobe_t strobe;

  // Upper address bits select the word, not the lane
  logic unusedAddrHi;
  assign unusedAddrHi = ^addr[DATA_W-1:LANE_IDX_W];

  lsu_align_ctrl i_ctrl (
    .reqValid   (reqValid),
    .reqIsStore (reqIsStore),
    .accessKind (accessKind),
    .addrLow    (addr[LANE_IDX_W-1:0]),
    .strobe     (strobe)
  );

  lsu_align_dpath i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .storeData  (storeData),
    .upperImm   (upperImm),
    .memRdata   (memRdata),
    .memWdata   (memWdata),
    .loadValid  (loadValid),
    .loadResult (loadResult)
  );

  assign memByteEn  = strobe.laneEn;
  assign misaligned = strobe.misalign;

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk
  import lsu_align_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqIsStore,
  input logic [KIND_W-1:0] accessKind,
  input logic [DATA_W-1:0] addr,
  input logic [DATA_W-1:0] storeData,
  input logic [IMM_W-1:0]  upperImm,
  input logic [LANES-1:0]  memByteEn,
  input logic [DATA_W-1:0] memWdata,
  input logic              misaligned,
  input logic              loadValid,
  input logic [DATA_W-1:0] loadResult
);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (memByteEn == '0 && !misaligned));

  assert_misalign_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (memByteEn == '0));

  assert_misalign_no_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && misaligned) |=> !loadValid);

  assert_store_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && accessKind == 3'd0 && addr[1:0] == 2'b00)
      |-> (memByteEn == 4'hF && memWdata == storeData));

  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsStore && (accessKind == 3'd3 || accessKind == 3'd4))
      |-> ($countones(memByteEn) == 1));

  assert_upper_imm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStore && accessKind == 3'd5)
      |=> (loadValid && loadResult == {$past(upperImm), 16'h0000}));

  assert_load_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsStore && !misaligned && accessKind <= 3'd5) |=> loadValid);

  assert_reserved_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accessKind[2:1] == 2'b11) |-> (memByteEn == '0 && !misaligned));

endmodule

bind lsu_lane_align lsu_lane_align_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqIsStore (reqIsStore),
  .accessKind (accessKind),
  .addr       (addr),
  .storeData  (storeData),
  .upperImm   (upperImm),
  .memByteEn  (memByteEn),
  .memWdata   (memWdata),
  .misaligned (misaligned),
  .loadValid  (loadValid),
  .loadResult (loadResult)
);

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsStore = 1'b0;
  logic [2:0]  accessKind = 3'd0;
  logic [31:0] addr = '0;
  logic [31:0] storeData = '0;
  logic [15:0] upperImm = '0;
  logic [31:0] memRdata = '0;
  logic [3:0]  memByteEn;
  logic [31:0] memWdata;
  logic        misaligned;
  logic        loadValid;
  logic [31:0] loadResult;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit          expValidQ[$];
  logic [31:0] expDataQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .accessKind(accessKind), .addr(addr), .storeData(storeData),
    .upperImm(upperImm), .memRdata(memRdata), .memByteEn(memByteEn),
    .memWdata(memWdata), .misaligned(misaligned), .loadValid(loadValid),
    .loadResult(loadResult)
  );

  function automatic bit isMis(input logic [2:0] k, input logic [1:0] a);
    if (k == 3'd0) return a != 2'b00;
    if (k == 3'd1 || k == 3'd2) return a[0];
    return 1'b0;
  endfunction

  function automatic bit legal(input bit st, input logic [2:0] k);
    if (k >= 3'd6) return 1'b0;
    if (st && k == 3'd5) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [3:0] expEn(input bit v, input bit st,
                                       input logic [2:0] k, input logic [1:0] a);
    if (!v || !st || !legal(st, k) || isMis(k, a)) return 4'b0000;
    if (k == 3'd0) return 4'b1111;
    if (k == 3'd1 || k == 3'd2) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << a;
  endfunction

  function automatic logic [31:0] expWd(input logic [2:0] k, input logic [31:0] d);
    if (k == 3'd1 || k == 3'd2) return {d[15:0], d[15:0]};
    if (k == 3'd3 || k == 3'd4) return {4{d[7:0]}};
    return d;
  endfunction

  function automatic logic [31:0] expLd(input logic [2:0] k, input logic [1:0] a,
                                        input logic [31:0] rd, input logic [15:0] im);
    logic [7:0]  b;
    logic [15:0] h;
    b = rd >> (8 * a);
    h = a[1] ? rd[31:16] : rd[15:0];
    case (k)
      3'd1: return {{16{h[15]}}, h};
      3'd2: return {16'h0000, h};
      3'd3: return {{24{b[7]}}, b};
      3'd4: return {24'h000000, b};
      3'd5: return {im, 16'h0000};
      default: return rd;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one request cycle, then one cycle returning the memory word
  task automatic access(input bit v, input bit st, input logic [2:0] k,
                        input logic [31:0] a, input logic [31:0] sd,
                        input logic [15:0] im, input logic [31:0] rd,
                        input string tag);
    logic [3:0] en;
    bit         mis;
    bit         ldOk;
    @(negedge clk);
    reqValid = v; reqIsStore = st; accessKind = k; addr = a;
    storeData = sd; upperImm = im; memRdata = 32'hDEAD_0BAD;
    expValidQ.push_back(1'b0); expDataQ.push_back('0); tagQ.push_back({tag, " idle-slot"});
    #1;
    en  = expEn(v, st, k, a[1:0]);
    mis = v && legal(st, k) && isMis(k, a[1:0]);
    check({tag, " byteEn"}, {28'h0, memByteEn}, {28'h0, en});
    check({tag, " misaligned"}, {31'h0, misaligned}, {31'h0, mis});
    if (en != 4'b0000) check({tag, " wdata"}, memWdata, expWd(k, sd));
    ldOk = v && !st && legal(st, k) && !isMis(k, a[1:0]);
    @(negedge clk);
    reqValid = 1'b0; memRdata = rd;
    expValidQ.push_back(ldOk); expDataQ.push_back(expLd(k, a[1:0], rd, im));
    tagQ.push_back({tag, " load"});
  endtask

  // Monitor: pop one expected item per cycle and compare
  always @(negedge clk) begin
    #1;
    if (tagQ.size() > 0) begin
      bit          ev;
      logic [31:0] ed;
      string       tg;
      ev = expValidQ.pop_front();
      ed = expDataQ.pop_front();
      tg = tagQ.pop_front();
      check({tg, " loadValid"}, {31'h0, loadValid}, {31'h0, ev});
      if (ev) check({tg, " result"}, loadResult, ed);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset loadValid", {31'h0, loadValid}, 32'h0);
    check("R11 reset byteEn", {28'h0, memByteEn}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R11 after reset loadValid", {31'h0, loadValid}, 32'h0);

    access(1, 1, 3'd0, 32'h0000_0100, 32'hA1B2_C3D4, 16'h0, 32'h0, "R1 store word");
    access(1, 1, 3'd1, 32'h0000_0200, 32'h1234_8765, 16'h0, 32'h0, "R2 store half low");
    access(1, 1, 3'd2, 32'h0000_0202, 32'h5555_ABCD, 16'h0, 32'h0, "R2 store half high");
    for (int i = 0; i < 4; i++) begin
      access(1, 1, (i % 2) ? 3'd4 : 3'd3, 32'h0000_0300 + i, 32'h0000_00E0 + i,
             16'h0, 32'h0, "R3 store byte lane");
    end
    access(1, 1, 3'd1, 32'h0000_0201, 32'hFFFF_FFFF, 16'h0, 32'h0, "R4 store half odd");
    access(1, 1, 3'd0, 32'h0000_0102, 32'hFFFF_FFFF, 16'h0, 32'h0, "R4 store word unaligned");
    access(1, 0, 3'd2, 32'h0000_0003, 32'h0, 16'h0, 32'h8899_AABB, "R4 load half misaligned");
    access(1, 0, 3'd0, 32'h0000_0001, 32'h0, 16'h0, 32'h1122_3344, "R4 load word misaligned");
    access(1, 0, 3'd0, 32'h0000_0400, 32'h0, 16'h0, 32'hCAFE_F00D, "R7 R9 load word");
    access(1, 0, 3'd1, 32'h0000_0400, 32'h0, 16'h0, 32'h0123_8001, "R5 half signed low neg");
    access(1, 0, 3'd1, 32'h0000_0402, 32'h0, 16'h0, 32'h7FFE_8001, "R5 half signed high pos");
    access(1, 0, 3'd1, 32'h0000_0402, 32'h0, 16'h0, 32'hF00D_0001, "R5 half signed high neg");
    access(1, 0, 3'd2, 32'h0000_0402, 32'h0, 16'h0, 32'hF00D_0001, "R6 half unsigned high");
    access(1, 0, 3'd2, 32'h0000_0400, 32'h0, 16'h0, 32'h0000_9ABC, "R6 half unsigned low");
    for (int i = 0; i < 4; i++) begin
      access(1, 0, 3'd3, 32'h0000_0500 + i, 32'h0, 16'h0, 32'h80_7F_FF_01, "R5 byte signed lane");
      access(1, 0, 3'd4, 32'h0000_0500 + i, 32'h0, 16'h0, 32'h80_7F_FF_01, "R6 byte unsigned lane");
    end
    access(1, 0, 3'd5, 32'h0000_0003, 32'h0, 16'hBEEF, 32'h1234_5678, "R8 upper imm");
    access(1, 0, 3'd5, 32'h0000_0000, 32'h0, 16'h8000, 32'hFFFF_FFFF, "R8 upper imm top");
    access(0, 1, 3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0, 32'h0, "R10 idle store");
    access(0, 0, 3'd0, 32'h0000_0000, 32'h0, 16'h0, 32'h7777_7777, "R10 idle load");
    access(1, 1, 3'd6, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0, 32'h0, "R12 reserved store 6");
    access(1, 1, 3'd5, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 32'h0, "R12 upper as store");
    access(1, 0, 3'd7, 32'h0000_0002, 32'h0, 16'h0, 32'h6666_6666, "R12 reserved load 7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule